// File: doc/BRIEF.md
# Local Interrupt Priority and Acceptance Unit

This block is the request side of a processor-local interrupt unit. It has 256 vectors. Three 256-bit state vectors are kept: requests waiting for the processor, requests currently being serviced, and the trigger kind each vector last arrived with. An 8-bit task priority sets a floor below which requests stay masked. The unit derives a processor priority from that floor and from the most important vector in service.

Upstream delivery logic presents one vector per cycle on the accept port, together with its trigger kind. A result flag tells the sender whether the request was newly recorded or merged into one that was already waiting. The processor side sees an interrupt-pending flag. An acknowledge request hands over the most important deliverable vector and moves it into service. An end-of-interrupt pulse retires the most important vector in service. A query port reads the three per-vector state bits of any one vector.

Top module: `lapic_acceptor`

## Requirements
- R1: On an enabled accept, the vector's trigger bit (read on `qry_tmr`) is set to 1 when `acc_level`=1 (level) and cleared to 0 when `acc_level`=0 (edge). The change is visible the cycle after the accept.
- R2: An enabled accept sets the vector's request bit. In the same cycle, `acc_fresh` is 1 only if that bit was 0 before; a repeat of a waiting vector gives `acc_fresh`=0 (merged).
- R3: While `sw_enable`=0, an accept has no effect: `acc_fresh`=0, and the request and trigger bits of the vector keep their values.
- R4: `ppr` equals the full task priority when task[7:4] >= S[7:4]; otherwise it equals S with the low nibble cleared (S & 0xF0). S is defined in R5.
- R5: S is the highest vector whose in-service bit is set, or 0 when no in-service bit is set.
- R6: When `ack_req`=1 and an interrupt is pending, `ack_valid`=1 and `ack_vector` carries the chosen vector in the same cycle. In the next cycle its in-service bit is 1, its request bit is 0, and `ppr` reflects the new in-service set.
- R7: The priority class of a vector is bits [7:4], and a larger value is more important. The acknowledged vector is always the highest-numbered vector with its request bit set.
- R8: `irq_pending` is 1 exactly when some request bit is set and the class of the highest requested vector is strictly greater than `ppr`[7:4]. An `ack_req` while nothing is pending gives `ack_valid`=0 and changes no state.
- R9: An `eoi` pulse clears the in-service bit of the highest in-service vector, and `ppr` is recomputed in the next cycle. An `eoi` while nothing is in service has no effect.
- R10: A task-priority write (`tpr_we`=1) takes effect in the next cycle's `ppr` and `irq_pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; clears all state |
| sw_enable | input | 1 | Unit enable; accepts are dropped while low |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 8 | New task priority |
| acc_valid | input | 1 | Accept a request this cycle |
| acc_vector | input | 8 | Vector of the incoming request |
| acc_level | input | 1 | Trigger kind: 1 level, 0 edge |
| acc_fresh | output | 1 | 1 when the accept recorded a new request |
| ack_req | input | 1 | Processor acknowledge request |
| ack_valid | output | 1 | A vector is handed over this cycle |
| ack_vector | output | 8 | Vector handed over (0 when `ack_valid`=0) |
| eoi | input | 1 | End-of-interrupt pulse |
| irq_pending | output | 1 | A deliverable request exists |
| ppr | output | 8 | Current processor priority |
| qry_vector | input | 8 | Vector to inspect |
| qry_irr | output | 1 | Request bit of `qry_vector` |
| qry_isr | output | 1 | In-service bit of `qry_vector` |
| qry_tmr | output | 1 | Trigger bit of `qry_vector` |

## Verification
The bound checker watches several rules on every cycle. It checks how accepts update the trigger and request bits. It checks that merged and disabled accepts never report a fresh request, that `ppr` never drops below the task priority, and that an acknowledged vector always outranks `ppr`. It also checks that an acknowledge moves its vector into service, and that an end-of-interrupt removes exactly one in-service bit. Other properties need a reference model that tracks the whole state, so only the bench scenarios show them. These are which vector wins among many requests, the exact `ppr` value as nested services start and retire, and the point where a changed task priority unmasks or masks a waiting class.

// File: rtl/lapic_pkg.sv
package lapic_pkg;

    localparam int VEC_W   = 8;
    localparam int NUM_VEC = 1 << VEC_W;
    localparam int CLS_W   = VEC_W / 2;

    typedef logic [VEC_W-1:0]   vec_t;
    typedef logic [NUM_VEC-1:0] vec_map_t;

    typedef struct packed {
        vec_map_t irr;
        vec_map_t isr;
        vec_map_t tmr;
        vec_t     tpr;
    } lapic_state_t;

endpackage

// File: rtl/lapic_hi_find.sv
// Finds the highest set bit of a wide vector: per-group search, then group select.
module lapic_hi_find #(
    parameter int W   = 256,
    parameter int GRP = 16
) (
    input  logic [W-1:0]         bits,
    output logic                 any,
    output logic [$clog2(W)-1:0] idx
);
    localparam int NG = W / GRP;
    localparam int GW = $clog2(GRP);
    localparam int NW = (NG > 1) ? $clog2(NG) : 1;

    logic [NG-1:0]         g_any;
    logic [NG-1:0][GW-1:0] g_idx;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        logic [GW-1:0] loc_idx;
        always_comb begin
            loc_idx = '0;
            for (int i = 0; i < GRP; i++) begin
                if (bits[g*GRP + i]) loc_idx = GW'(i);
            end
        end
        assign g_any[g] = |bits[g*GRP +: GRP];
        assign g_idx[g] = loc_idx;
    end

    logic [NW-1:0] sel;
    always_comb begin
        sel = '0;
        for (int g = 0; g < NG; g++) begin
            if (g_any[g]) sel = NW'(g);
        end
    end

    assign any = |g_any;
    assign idx = $clog2(W)'({sel, g_idx[sel]});
endmodule

// File: rtl/lapic_vec_decode.sv
// Vector number to one-hot mask, gated by an enable.
module lapic_vec_decode #(
    parameter int VEC_W = 8
) (
    input  logic                  en,
    input  logic [VEC_W-1:0]      vec,
    output logic [(1<<VEC_W)-1:0] onehot
);
    localparam int N = 1 << VEC_W;
    always_comb begin
        onehot = '0;
        if (en) onehot[vec] = 1'b1;
    end
endmodule

// File: rtl/lapic_prio_calc.sv
// Processor priority and deliverability from task priority and the highest vectors.
module lapic_prio_calc #(
    parameter int VEC_W = 8
) (
    input  logic [VEC_W-1:0] tpr,
    input  logic             isr_any,
    input  logic [VEC_W-1:0] isr_hi,
    input  logic             irr_any,
    input  logic [VEC_W-1:0] irr_hi,
    output logic [VEC_W-1:0] ppr,
    output logic             pending
);
    localparam int CLS_W = VEC_W / 2;
    localparam int SUB_W = VEC_W - CLS_W;

    logic [VEC_W-1:0] svc_top;
    logic [CLS_W-1:0] tpr_cls, svc_cls, irr_cls, ppr_cls;

    always_comb begin
        svc_top = isr_any ? isr_hi : '0;
        tpr_cls = tpr[VEC_W-1 -: CLS_W];
        svc_cls = svc_top[VEC_W-1 -: CLS_W];
        if (tpr_cls >= svc_cls) ppr = tpr;
        else                    ppr = {svc_cls, {SUB_W{1'b0}}};
        ppr_cls = ppr[VEC_W-1 -: CLS_W];
        irr_cls = irr_hi[VEC_W-1 -: CLS_W];
        pending = irr_any && (irr_cls > ppr_cls);
    end
endmodule

// File: rtl/lapic_acceptor.sv
module lapic_acceptor
    import lapic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_enable,
    input  logic       tpr_we,
    input  logic [7:0] tpr_wdata,
    input  logic       acc_valid,
    input  logic [7:0] acc_vector,
    input  logic       acc_level,
    output logic       acc_fresh,
    input  logic       ack_req,
    output logic       ack_valid,
    output logic [7:0] ack_vector,
    input  logic       eoi,
    output logic       irq_pending,
    output logic [7:0] ppr,
    input  logic [7:0] qry_vector,
    output logic       qry_irr,
    output logic       qry_isr,
    output logic       qry_tmr
);
    lapic_state_t st_d, st_q;

    // Named views of the state for the bound checker.
    vec_map_t irr_cur, isr_cur, tmr_cur;
    vec_t     tpr_cur;
    assign irr_cur = st_q.irr;
    assign isr_cur = st_q.isr;
    assign tmr_cur = st_q.tmr;
    assign tpr_cur = st_q.tpr;

    logic irr_any, isr_any;
    vec_t irr_hi, isr_hi;

    lapic_hi_find #(.W(NUM_VEC), .GRP(16)) u_irr_hi (
        .bits(st_q.irr), .any(irr_any), .idx(irr_hi)
    );
    lapic_hi_find #(.W(NUM_VEC), .GRP(16)) u_isr_hi (
        .bits(st_q.isr), .any(isr_any), .idx(isr_hi)
    );

    lapic_prio_calc #(.VEC_W(VEC_W)) u_prio (
        .tpr(st_q.tpr), .isr_any(isr_any), .isr_hi(isr_hi),
        .irr_any(irr_any), .irr_hi(irr_hi),
        .ppr(ppr), .pending(irq_pending)
    );

    logic acc_take, eoi_take;
    assign acc_take  = acc_valid & sw_enable;
    assign eoi_take  = eoi & isr_any;
    assign ack_valid = ack_req & irq_pending;

    vec_map_t acc_mask, ack_mask, eoi_mask;

    lapic_vec_decode #(.VEC_W(VEC_W)) u_acc_dec (
        .en(acc_take), .vec(acc_vector), .onehot(acc_mask)
    );
    lapic_vec_decode #(.VEC_W(VEC_W)) u_ack_dec (
        .en(ack_valid), .vec(irr_hi), .onehot(ack_mask)
    );
    lapic_vec_decode #(.VEC_W(VEC_W)) u_eoi_dec (
        .en(eoi_take), .vec(isr_hi), .onehot(eoi_mask)
    );

    always_comb begin
        acc_fresh  = acc_take & ~st_q.irr[acc_vector];
        ack_vector = ack_valid ? irr_hi : '0;
        qry_irr    = st_q.irr[qry_vector];
        qry_isr    = st_q.isr[qry_vector];
        qry_tmr    = st_q.tmr[qry_vector];
    end

    always_comb begin
        st_d = st_q;
        if (tpr_we) st_d.tpr = tpr_wdata;
        st_d.irr = (st_q.irr & ~ack_mask) | acc_mask;
        st_d.isr = (st_q.isr & ~eoi_mask) | ack_mask;
        if (acc_take) begin
            if (acc_level) st_d.tmr = st_q.tmr | acc_mask;
            else           st_d.tmr = st_q.tmr & ~acc_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lapic_acceptor_chk.sv
module lapic_acceptor_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         sw_enable,
    input logic         acc_valid,
    input logic [7:0]   acc_vector,
    input logic         acc_level,
    input logic         acc_fresh,
    input logic         ack_valid,
    input logic [7:0]   ack_vector,
    input logic         eoi,
    input logic [7:0]   ppr,
    input logic [255:0] irr_cur,
    input logic [255:0] isr_cur,
    input logic [255:0] tmr_cur,
    input logic [7:0]   tpr_cur
);
    logic same_vec;
    assign same_vec = ack_valid && (ack_vector == acc_vector);

    p_tmr_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && sw_enable && acc_level) |=> tmr_cur[$past(acc_vector)]);

    p_tmr_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && sw_enable && !acc_level) |=> !tmr_cur[$past(acc_vector)]);

    p_irr_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && sw_enable) |=> irr_cur[$past(acc_vector)]);

    p_merge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && irr_cur[acc_vector]) |-> !acc_fresh);

    p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !sw_enable) |-> !acc_fresh);

    p_disabled_tmr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(acc_valid && sw_enable)) |=> $stable(tmr_cur));

    p_ppr_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ppr >= tpr_cur) && ((ppr == tpr_cur) || (ppr[3:0] == 4'h0)));

    p_ack_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !(acc_valid && sw_enable && same_vec))
        |=> (isr_cur[$past(ack_vector)] && !irr_cur[$past(ack_vector)]));

    p_ack_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (ack_vector[7:4] > ppr[7:4]));

    p_eoi_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !ack_valid && (isr_cur != '0))
        |=> ($countones(isr_cur) == $past($countones(isr_cur)) - 1));
endmodule

bind lapic_acceptor lapic_acceptor_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable),
    .acc_valid(acc_valid), .acc_vector(acc_vector), .acc_level(acc_level),
    .acc_fresh(acc_fresh), .ack_valid(ack_valid), .ack_vector(ack_vector),
    .eoi(eoi), .ppr(ppr),
    .irr_cur(irr_cur), .isr_cur(isr_cur), .tmr_cur(tmr_cur), .tpr_cur(tpr_cur)
);

// File: tb/lapic_acceptor_bench.sv
`timescale 1ns/1ps
module lapic_acceptor_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_enable = 1'b0, tpr_we = 1'b0, acc_valid = 1'b0, acc_level = 1'b0;
    logic       ack_req = 1'b0, eoi = 1'b0;
    logic [7:0] tpr_wdata = '0, acc_vector = '0, qry_vector = '0;
    logic       acc_fresh, ack_valid, irq_pending, qry_irr, qry_isr, qry_tmr;
    logic [7:0] ack_vector, ppr;

    always #2 clk = ~clk;

    lapic_acceptor u_lapic_acceptor (
        .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
        .acc_valid(acc_valid), .acc_vector(acc_vector), .acc_level(acc_level),
        .acc_fresh(acc_fresh), .ack_req(ack_req), .ack_valid(ack_valid),
        .ack_vector(ack_vector), .eoi(eoi), .irq_pending(irq_pending), .ppr(ppr),
        .qry_vector(qry_vector), .qry_irr(qry_irr), .qry_isr(qry_isr), .qry_tmr(qry_tmr)
    );

    int n_chk = 0, n_fail = 0;
    logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
    logic [7:0]   m_tpr = '0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int hi_of(logic [255:0] b);
        int r = -1;
        for (int i = 0; i < 256; i++) if (b[i]) r = i;
        return r;
    endfunction

    function automatic logic [7:0] ppr_of(logic [7:0] t, logic [255:0] s);
        int h = hi_of(s);
        logic [7:0] sv = (h < 0) ? 8'h00 : 8'(h);
        if (t[7:4] >= sv[7:4]) return t;
        return {sv[7:4], 4'h0};
    endfunction

    function automatic logic pend_of(logic [7:0] t, logic [255:0] r, logic [255:0] s);
        int h = hi_of(r);
        logic [7:0] p = ppr_of(t, s);
        logic [7:0] hv = 8'(h);
        return (h >= 0) && (hv[7:4] > p[7:4]);
    endfunction

    // One cycle: drive at the falling edge, compare, then advance the model at the rising edge.
    task automatic step(logic en, logic tw, logic [7:0] td, logic av, logic [7:0] avec,
                        logic alvl, logic ar, logic e, logic [7:0] q);
        logic [7:0] e_ppr;
        logic e_pend, e_ack, e_fresh;
        int irh, ish;
        @(negedge clk);
        sw_enable = en; tpr_we = tw; tpr_wdata = td; acc_valid = av; acc_vector = avec;
        acc_level = alvl; ack_req = ar; eoi = e; qry_vector = q;
        #0.5;
        e_ppr   = ppr_of(m_tpr, m_isr);
        e_pend  = pend_of(m_tpr, m_irr, m_isr);
        e_ack   = ar && e_pend;
        e_fresh = en && av && !m_irr[avec];
        irh = hi_of(m_irr);
        ish = hi_of(m_isr);
        chk(en ? "R2 acc_fresh" : "R3 acc_fresh", int'(acc_fresh), int'(e_fresh));
        chk("R4 ppr", int'(ppr), int'(e_ppr));
        chk("R8 irq_pending", int'(irq_pending), int'(e_pend));
        chk("R6 ack_valid", int'(ack_valid), int'(e_ack));
        chk("R7 ack_vector", int'(ack_vector), e_ack ? irh : 0);
        chk("R2 qry_irr", int'(qry_irr), int'(m_irr[q]));
        chk("R9 qry_isr", int'(qry_isr), int'(m_isr[q]));
        chk("R1 qry_tmr", int'(qry_tmr), int'(m_tmr[q]));
        @(posedge clk);
        if (tw) m_tpr = td;
        if (e && ish >= 0) m_isr[ish] = 1'b0;
        if (e_ack) begin
            m_irr[irh] = 1'b0;
            m_isr[irh] = 1'b1;
        end
        if (en && av) begin
            m_irr[avec] = 1'b1;
            m_tmr[avec] = alvl;
        end
    endtask

    task automatic idle(logic [7:0] q);
        step(1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, q);
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #0.5;
        chk("R4 reset ppr", int'(ppr), 0);
        chk("R8 reset irq_pending", int'(irq_pending), 0);
        chk("R2 reset qry_irr", int'(qry_irr), 0);

        // R1/R2: level accept, then a merged edge accept of the same vector
        step(1, 0, 0, 1, 8'h35, 1, 0, 0, 8'h35);
        chk("R2 first accept fresh", int'(acc_fresh), 1);
        idle(8'h35);
        chk("R1 level sets tmr", int'(qry_tmr), 1);
        step(1, 0, 0, 1, 8'h35, 0, 0, 0, 8'h35);
        chk("R2 repeat merged", int'(acc_fresh), 0);
        idle(8'h35);
        chk("R1 edge clears tmr", int'(qry_tmr), 0);

        // R3: disabled accept leaves no trace
        step(0, 0, 0, 1, 8'h90, 1, 0, 0, 8'h90);
        chk("R3 disabled not fresh", int'(acc_fresh), 0);
        idle(8'h90);
        chk("R3 disabled irr", int'(qry_irr), 0);
        chk("R3 disabled tmr", int'(qry_tmr), 0);

        // R6: acknowledge 0x35
        step(1, 0, 0, 0, 0, 0, 1, 0, 8'h35);
        chk("R6 ack vector", int'(ack_vector), 8'h35);
        idle(8'h35);
        chk("R6 isr set", int'(qry_isr), 1);
        chk("R6 irr cleared", int'(qry_irr), 0);
        chk("R5 ppr from in-service", int'(ppr), 8'h30);

        // R8/R7: same class masked, higher class wins
        step(1, 0, 0, 1, 8'h3A, 1, 0, 0, 0);
        idle(0);
        chk("R8 same class masked", int'(irq_pending), 0);
        step(1, 0, 0, 1, 8'h47, 0, 0, 0, 0);
        step(1, 0, 0, 1, 8'h41, 0, 1, 0, 0);
        chk("R8 higher class pending", int'(irq_pending), 1);
        chk("R7 highest vector chosen", int'(ack_vector), 8'h47);
        idle(0);
        chk("R4 nested ppr", int'(ppr), 8'h40);
        step(1, 0, 0, 0, 0, 0, 1, 0, 0);
        chk("R8 ack without pending", int'(ack_valid), 0);

        // R9: retire in order; empty retire is harmless
        step(1, 0, 0, 0, 0, 0, 0, 1, 8'h47);
        idle(8'h47);
        chk("R9 eoi clears top", int'(qry_isr), 0);
        chk("R9 ppr back", int'(ppr), 8'h30);
        step(1, 0, 0, 0, 0, 0, 0, 1, 8'h35);
        idle(8'h35);
        chk("R5 empty isr ppr", int'(ppr), 8'h00);
        step(1, 0, 0, 0, 0, 0, 0, 1, 0);
        idle(0);
        chk("R9 empty eoi no effect", int'(ppr), 8'h00);

        // R10: task priority masks and unmasks
        step(1, 1, 8'h57, 0, 0, 0, 0, 0, 0);
        chk("R10 ppr before write lands", int'(ppr), 0);
        idle(0);
        chk("R10 ppr after write", int'(ppr), 8'h57);
        chk("R10 masked by tpr", int'(irq_pending), 0);
        step(1, 1, 8'h20, 0, 0, 0, 0, 0, 0);
        idle(0);
        chk("R10 unmasked by tpr", int'(irq_pending), 1);

        // Random mix
        for (int k = 0; k < 4000; k++) begin
            step(($urandom % 10) != 0, ($urandom % 25) == 0, 8'($urandom),
                 ($urandom % 2) == 0, 8'($urandom), 1'($urandom),
                 ($urandom % 5) < 2, ($urandom % 6) == 0, 8'($urandom));
        end
        for (int k = 0; k < 300; k++) step(1, k == 0, 8'h00, 0, 0, 0, 1, 1, 8'($urandom));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule